// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block is the digital controller for one H-bridge winding. It turns a direction bit, a two-bit current level, a sampled winding current and a reference code into four gate enables: a high-side and a low-side switch on each leg. While the winding is driven it compares the current sample against a threshold on every clock. The threshold is the reference scaled by one of three fixed ratios.

When the current reaches the threshold, only the high-side switch is released, for a programmed number of cycles. The low-side switch stays on, so the current recirculates slowly. After that the high-side switch returns.

Every change of direction, and every exit from a shutdown, passes through a dead interval in which all four switches are off. For a short blanking interval after each high-side turn-on, the comparator is ignored. Three conditions force the bridge fully off:

- the "zero" level code;
- an over-temperature latch with hysteresis;
- an undervoltage flag.

Top module: `bridge_chopper`

## Requirements
- R1: While reset is asserted, and after it is released until the first dead interval ends, all four gate enables are 0.
- R2: The trip threshold is (ref_code*K)>>16, with K=6554 for lvl_sel 2'b00 (full), 4369 for 2'b01 (two-thirds) and 2185 for 2'b10 (one-third). A trip is a sample with sense >= threshold.
- R3: lvl_sel 2'b11 turns all four enables off one clock later and holds them off. Leaving 2'b11 re-enables the bridge through a full dead interval.
- R4: Gate vector {src_a,snk_a,src_b,snk_b} is 4'b1001 when driving with dir=1 and 4'b0110 with dir=0.
- R5: A trip outside blanking gives 4'b0001 (dir=1) or 4'b0100 (dir=0) on the next clock, for OFF_CYC cycles. The driving pair then returns.
- R6: A change of dir while driving or chopping turns all enables off for DEAD_CYC cycles. The new pair is then enabled.
- R7: For BLANK_CYC cycles after each high-side turn-on, trips are ignored. A trip held from turn-on chops on the clock after those cycles.
- R8: temp >= HOT_CODE (170) turns all enables off on the next clock. They stay off until temp <= COOL_CODE (145), then re-enable through a dead interval.
- R9: uv_lock high turns all enables off on the next clock. Release re-enables through a dead interval.
- R10: Priorities are shutdown first, then direction change, then trip. A trip in the same cycle as a direction change or a shutdown yields all-off, not a chop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Requested current direction |
| lvl_sel | input | 2 | Current level select |
| sense | input | SW | Sampled winding current |
| ref_code | input | RW | Reference code |
| temp | input | TW | Die temperature code |
| uv_lock | input | 1 | Logic-supply undervoltage flag |
| src_a | output | 1 | Leg A high-side enable |
| snk_a | output | 1 | Leg A low-side enable |
| src_b | output | 1 | Leg B high-side enable |
| snk_b | output | 1 | Leg B low-side enable |

## Verification
Two functions can meet in one clock: a comparator trip, and a direction flip or a shutdown request. The bench sets the current sample above the threshold on the same edge as it flips direction, and again on the same edge as it selects the zero level. It expects all-off on the next clock rather than a chop pattern. In the direction case it then expects the new pair after the dead interval, and a chop only once blanking has run out.

// File: rtl/bridge_chopper.sv
module bridge_chopper #(
  parameter int SW        = 12,
  parameter int RW        = 12,
  parameter int TW        = 8,
  parameter int OFF_CYC   = 460,
  parameter int DEAD_CYC  = 20,
  parameter int BLANK_CYC = 20,
  parameter int HOT_CODE  = 170,
  parameter int COOL_CODE = 145
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic [1:0]    lvl_sel,
  input  logic [SW-1:0] sense,
  input  logic [RW-1:0] ref_code,
  input  logic [TW-1:0] temp,
  input  logic          uv_lock,
  output logic          src_a,
  output logic          snk_a,
  output logic          src_b,
  output logic          snk_b
);
  localparam int FRAC = 16;
  localparam int PW   = RW + FRAC;
  localparam int MAXC = (OFF_CYC > DEAD_CYC) ? ((OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC)
                                             : ((DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] K_FULL = PW'(((1 << FRAC) + 5) / 10);
  localparam logic [PW-1:0] K_TWO  = PW'(((1 << FRAC) + 7) / 15);
  localparam logic [PW-1:0] K_ONE  = PW'(((1 << FRAC) + 15) / 30);

  typedef enum logic [1:0] {S_OFF, S_DEAD, S_ON, S_CHOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dir_q;
  logic          hot_q;
  logic          hot_d;
  logic          kill;
  logic [PW-1:0] k_sel;
  logic [PW-1:0] thr;
  logic          trip;

  assign hot_d = hot_q ? (temp > TW'(COOL_CODE)) : (temp >= TW'(HOT_CODE));
  assign kill  = hot_d | uv_lock | (lvl_sel == 2'b11);

  always_comb begin
    case (lvl_sel)
      2'b00:   k_sel = K_FULL;
      2'b01:   k_sel = K_TWO;
      default: k_sel = K_ONE;
    endcase
  end

  assign thr  = (PW'(ref_code) * k_sel) >> FRAC;
  assign trip = PW'(sense) >= thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_OFF;
      cnt   <= '0;
      dir_q <= 1'b0;
      hot_q <= 1'b0;
    end else begin
      hot_q <= hot_d;
      if (kill) begin
        st  <= S_OFF;
        cnt <= '0;
      end else begin
        case (st)
          S_OFF: begin
            st  <= S_DEAD;
            cnt <= CW'(DEAD_CYC - 1);
          end
          S_DEAD: begin
            if (cnt == '0) begin
              st    <= S_ON;
              dir_q <= dir;
              cnt   <= CW'(BLANK_CYC);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_ON: begin
            if (dir != dir_q) begin
              st  <= S_DEAD;
              cnt <= CW'(DEAD_CYC - 1);
            end else if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else if (trip) begin
              st  <= S_CHOP;
              cnt <= CW'(OFF_CYC - 1);
            end
          end
          default: begin
            if (dir != dir_q) begin
              st  <= S_DEAD;
              cnt <= CW'(DEAD_CYC - 1);
            end else if (cnt == '0) begin
              st  <= S_ON;
              cnt <= CW'(BLANK_CYC);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign src_a = (st == S_ON) &  dir_q;
  assign src_b = (st == S_ON) & ~dir_q;
  assign snk_b = ((st == S_ON) | (st == S_CHOP)) &  dir_q;
  assign snk_a = ((st == S_ON) | (st == S_CHOP)) & ~dir_q;
endmodule

module bridge_chopper_chk #(
  parameter int TW       = 8,
  parameter int HOT_CODE = 170
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    lvl_sel,
  input logic [TW-1:0] temp,
  input logic          uv_lock,
  input logic          src_a,
  input logic          snk_a,
  input logic          src_b,
  input logic          snk_b
);
  a_r3_zero_level_off: assert property (@(posedge clk) disable iff (rst)
    (lvl_sel == 2'b11) |=> !(src_a || snk_a || src_b || snk_b));

  a_r8_hot_off: assert property (@(posedge clk) disable iff (rst)
    (temp >= TW'(HOT_CODE)) |=> !(src_a || snk_a || src_b || snk_b));

  a_r9_uv_off: assert property (@(posedge clk) disable iff (rst)
    uv_lock |=> !(src_a || snk_a || src_b || snk_b));

  a_r6_no_direct_a_to_b: assert property (@(posedge clk) disable iff (rst)
    ($past(src_a) || $past(snk_b)) |-> !(src_b || snk_a));

  a_r6_no_direct_b_to_a: assert property (@(posedge clk) disable iff (rst)
    ($past(src_b) || $past(snk_a)) |-> !(src_a || snk_b));

  a_r7_blank_a: assert property (@(posedge clk) disable iff (rst)
    $rose(src_a) |=> !(snk_b && !src_a));

  a_r7_blank_b: assert property (@(posedge clk) disable iff (rst)
    $rose(src_b) |=> !(snk_a && !src_b));

  a_r4_one_pair: assert property (@(posedge clk) disable iff (rst)
    !((src_a || snk_b) && (src_b || snk_a)));
endmodule

bind bridge_chopper bridge_chopper_chk #(.TW(TW), .HOT_CODE(HOT_CODE)) chk_i (
  .clk(clk), .rst(rst), .lvl_sel(lvl_sel), .temp(temp), .uv_lock(uv_lock),
  .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b)
);

// File: tb/bridge_chopper_tb.sv
module bridge_chopper_tb_top;
  localparam int SW = 12, RW = 12, TW = 8;
  localparam int OFF = 12, DEAD = 3, BLANK = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir = 1'b1;
  logic [1:0]    lvl_sel = 2'b00;
  logic [SW-1:0] sense = '0;
  logic [RW-1:0] ref_code = 12'd1000;
  logic [TW-1:0] temp = 8'd25;
  logic          uv_lock = 1'b0;
  logic          src_a, snk_a, src_b, snk_b;
  logic [3:0]    g;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;
  assign g = {src_a, snk_a, src_b, snk_b};

  bridge_chopper #(.SW(SW), .RW(RW), .TW(TW), .OFF_CYC(OFF), .DEAD_CYC(DEAD),
                   .BLANK_CYC(BLANK), .HOT_CODE(170), .COOL_CODE(145)) dut_i (
    .clk(clk), .rst(rst), .dir(dir), .lvl_sel(lvl_sel), .sense(sense),
    .ref_code(ref_code), .temp(temp), .uv_lock(uv_lock),
    .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if (g !== exp) begin
      n_bad++;
      $display("FAIL %s: gates %b expected %b", req, g, exp);
    end
  endtask

  function automatic int thr_of(input int r, input int l);
    int k;
    k = (l == 0) ? 6554 : (l == 1) ? 4369 : 2185;
    return (r * k) >> 16;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int refs[4];
    refs = '{123, 1000, 2047, 4095};
    tick(3);
    chk("R1 in reset", 4'b0000);
    rst = 1'b0;
    tick(DEAD);
    chk("R1 before first dead end", 4'b0000);
    tick(1);
    chk("R4 dir=1 pair", 4'b1001);
    tick(BLANK);

    foreach (refs[i]) begin
      for (int l = 0; l < 3; l++) begin
        int t;
        ref_code = RW'(refs[i]);
        lvl_sel  = 2'(l);
        t = thr_of(refs[i], l);
        sense = SW'(t - 1);
        tick(1);
        chk($sformatf("R2 below thr ref=%0d lvl=%0d", refs[i], l), 4'b1001);
        sense = SW'(t);
        tick(1);
        chk($sformatf("R2 at thr ref=%0d lvl=%0d", refs[i], l), 4'b0001);
        sense = '0;
        tick(OFF - 1);
        chk("R5 off-time held", 4'b0001);
        tick(1);
        chk("R5 source back", 4'b1001);
        tick(BLANK);
      end
    end

    lvl_sel = 2'b00;
    ref_code = 12'd1000;
    sense = 12'd4095;
    tick(1);
    chk("R5 chop", 4'b0001);
    tick(OFF);
    chk("R5 source back", 4'b1001);
    tick(BLANK);
    chk("R7 trip masked in blank", 4'b1001);
    tick(1);
    chk("R7 trip after blank", 4'b0001);
    sense = '0;
    tick(OFF + BLANK);

    dir = 1'b0;
    tick(1);
    chk("R6 dead start", 4'b0000);
    tick(DEAD - 1);
    chk("R6 dead end", 4'b0000);
    tick(1);
    chk("R4 dir=0 pair", 4'b0110);
    tick(BLANK);
    sense = SW'(thr_of(1000, 0));
    tick(1);
    chk("R5 chop dir=0", 4'b0100);
    dir = 1'b1;
    sense = '0;
    tick(1);
    chk("R6 dead from chop", 4'b0000);
    tick(DEAD);
    chk("R6 new pair after chop", 4'b1001);
    tick(BLANK);

    sense = 12'd4095;
    dir = 1'b0;
    tick(1);
    chk("R10 dir change beats trip", 4'b0000);
    tick(DEAD);
    chk("R10 new pair", 4'b0110);
    tick(BLANK);
    chk("R7 blank dir=0", 4'b0110);
    tick(1);
    chk("R7 chop after blank dir=0", 4'b0100);
    sense = '0;
    tick(OFF);
    chk("R5 back dir=0", 4'b0110);
    tick(BLANK);

    lvl_sel = 2'b11;
    tick(1);
    chk("R3 zero level off", 4'b0000);
    tick(5);
    chk("R3 zero level held", 4'b0000);
    lvl_sel = 2'b00;
    tick(DEAD);
    chk("R3 dead on exit", 4'b0000);
    tick(1);
    chk("R3 re-enabled", 4'b0110);
    tick(BLANK);
    sense = 12'd4095;
    lvl_sel = 2'b11;
    tick(1);
    chk("R10 shutdown beats trip", 4'b0000);
    sense = '0;
    lvl_sel = 2'b00;
    tick(DEAD + 1);
    chk("R10 recovered", 4'b0110);

    uv_lock = 1'b1;
    tick(1);
    chk("R9 uv off", 4'b0000);
    tick(4);
    chk("R9 uv held", 4'b0000);
    uv_lock = 1'b0;
    tick(DEAD);
    chk("R9 dead on release", 4'b0000);
    tick(1);
    chk("R9 re-enabled", 4'b0110);

    temp = 8'd169;
    tick(3);
    chk("R8 below hot", 4'b0110);
    temp = 8'd170;
    tick(1);
    chk("R8 hot off", 4'b0000);
    temp = 8'd150;
    tick(3);
    chk("R8 hysteresis 150", 4'b0000);
    temp = 8'd146;
    tick(3);
    chk("R8 hysteresis 146", 4'b0000);
    temp = 8'd145;
    tick(DEAD);
    chk("R8 dead on cool", 4'b0000);
    tick(1);
    chk("R8 re-enabled", 4'b0110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule